// File: doc/BRIEF.md
# Fractional-N Bit Clock Generator

This block produces an audio bit clock from a faster reference clock when the wanted rate is not an integer fraction of the reference. Two programmable integers, a numerator N and a denominator M, set the ratio. The average output frequency is the reference frequency times N/M. The output is built from two neighbouring integer periods of the reference. For example, N = 192 and M = 625 on a 40 MHz reference give 12.288 MHz on average, made of 3-cycle and 4-cycle periods. N = 441 and M = 6250 give 2.8224 MHz for the 44.1 kHz family, made of 14-cycle and 15-cycle periods.

Each reference cycle, a phase accumulator adds N modulo M. Each wrap ends one output period. The high phase of a period is set from the accumulator value at the start of the period, so the period length does not have to be known in advance. A one-cycle strobe marks the first reference cycle of every output period. The block also keeps the shortest and longest period it has produced, so that jitter can be read off directly:

jitter = max(|Tmin − Tideal|, |Tmax − Tideal|) / Tideal, where Tideal = M/N reference cycles.

Top module: `fracn_bclk_gen`

## Requirements
- R1: With a fixed valid N and M, any window of M reference cycles that begins on a period strobe contains exactly N period strobes.
- R2: Every output period lasts either floor(M/N) or ceil(M/N) reference cycles. For N=192, M=625 the lengths are only 3 and 4. For N=441, M=6250 they are only 14 and 15.
- R3: A period of L reference cycles is high for the first floor(L/2) cycles and low for the rest. For N=3, M=6 every period is 2 cycles with 1 high. For the first period after loading N=2, M=7 the length is 4 with 2 high.
- R4: `period_o` is high for exactly the first cycle of each output period. It is only ever high while `bclk_o` is high.
- R5: N=0 or 2N>M is invalid. An invalid pair keeps an idle block idle, with both outputs low. If an invalid pair is present at a period boundary, the block stops there.
- R6: Changes on `ratio_n`/`ratio_m` are taken only at a period boundary. If the values differ from those in use, the accumulator restarts from zero. Otherwise the accumulator keeps its remainder. The period running at the time of the change keeps its old length.
- R7: `min_len_o` and `max_len_o` reset to all ones and zero. Both are cleared to these values whenever the block starts from idle. They are updated with each completed period length.
- R8: When `en` is sampled low, both outputs are low from the next edge onward. When `en` is sampled high again, the block restarts with the accumulator at zero, and the first strobe appears two edges after the sampling edge.
- R9: After reset, `bclk_o` and `period_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable |
| ratio_n | input | W | Numerator N |
| ratio_m | input | W | Denominator M |
| bclk_o | output | 1 | Generated bit clock (registered) |
| period_o | output | 1 | Strobe on the first reference cycle of each output period |
| min_len_o | output | W | Shortest completed period, in reference cycles |
| max_len_o | output | W | Longest completed period, in reference cycles |

## Verification
`en` and the ratio inputs are sampled on one edge. The internal state moves on that edge, and the registered clock and strobe for that state show after the following edge. So the first strobe after enabling is due two edges after `en` is sampled high, while gating off shows after a single edge. The period statistics are written on the edge that ends the last cycle of a period, and are visible during the last output cycle of that period. A behavioural model in the bench works out each period length with a ceiling division from the remainder. It advances on every rising edge with the same input sampling. Its predictions are compared against all four outputs on the falling edge, so each result is checked in the exact cycle it is due. Extra window counts and period measurements cover the average rate, the two-length mix, the boundary-only update and the invalid pairs.

// File: rtl/fracn_bclk_gen.sv
module fracn_bclk_gen #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] ratio_n,
  input  logic [W-1:0] ratio_m,
  output logic         bclk_o,
  output logic         period_o,
  output logic [W-1:0] min_len_o,
  output logic [W-1:0] max_len_o
);
  localparam int XW = W + 2;

  logic         run, first;
  logic [W-1:0] n_q, m_q, acc, acc0, cnt;

  wire          in_ok   = (ratio_n != '0) && ({ratio_n, 1'b0} <= {1'b0, ratio_m});
  wire          changed = (ratio_n != n_q) || (ratio_m != m_q);
  wire [W:0]    sum     = {1'b0, acc} + {1'b0, n_q};
  wire          wrap    = sum >= {1'b0, m_q};
  wire [W:0]    rem_x   = sum - {1'b0, m_q};
  wire [W-1:0]  rem     = rem_x[W-1:0];
  wire [W-1:0]  len     = cnt + 1'b1;
  wire [XW-1:0] probe   = {1'b0, acc, 1'b0} + XW'(n_q) - XW'(acc0);
  wire          hi      = probe < XW'(m_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run       <= 1'b0;
      first     <= 1'b0;
      n_q       <= '0;
      m_q       <= '0;
      acc       <= '0;
      acc0      <= '0;
      cnt       <= '0;
      bclk_o    <= 1'b0;
      period_o  <= 1'b0;
      min_len_o <= '1;
      max_len_o <= '0;
    end else begin
      bclk_o   <= run & en & hi;
      period_o <= run & en & first;
      if (!run) begin
        if (en && in_ok) begin
          run       <= 1'b1;
          first     <= 1'b1;
          n_q       <= ratio_n;
          m_q       <= ratio_m;
          acc       <= '0;
          acc0      <= '0;
          cnt       <= '0;
          min_len_o <= '1;
          max_len_o <= '0;
        end
      end else if (!en) begin
        run   <= 1'b0;
        first <= 1'b0;
      end else if (wrap) begin
        if (len < min_len_o) min_len_o <= len;
        if (len > max_len_o) max_len_o <= len;
        cnt <= '0;
        if (in_ok) begin
          first <= 1'b1;
          n_q   <= ratio_n;
          m_q   <= ratio_m;
          acc   <= changed ? '0 : rem;
          acc0  <= changed ? '0 : rem;
        end else begin
          run   <= 1'b0;
          first <= 1'b0;
        end
      end else begin
        acc   <= sum[W-1:0];
        cnt   <= cnt + 1'b1;
        first <= 1'b0;
      end
    end
  end

  assert_strobe_in_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    period_o |-> bclk_o);

  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!bclk_o && !period_o));

  assert_ratio_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !first) |-> ($stable(n_q) && $stable(m_q)));

  assert_stats_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (max_len_o != '0) |-> (min_len_o <= max_len_o));

  assert_gate_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!bclk_o && !period_o));

endmodule

// File: tb/sim_fracn_bclk_gen.sv
`timescale 1ns/1ps
module sim_fracn_bclk_gen;
  logic        clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [15:0] n_in = '0, m_in = '0;
  logic        bclk_o, period_o;
  logic [15:0] min_len_o, max_len_o;

  fracn_bclk_gen #(.W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .ratio_n(n_in), .ratio_m(m_in),
    .bclk_o(bclk_o), .period_o(period_o), .min_len_o(min_len_o), .max_len_o(max_len_o)
  );

  always #2.5 clk = ~clk;

  int    tests = 0, fails = 0;
  string req = "R9";
  bit    cmp_on = 0;

  bit m_run = 0, e_bclk = 0, e_per = 0;
  int m_n = 1, m_m = 2, m_rem = 0, m_L = 2, m_k = 0, e_min = 65535, e_max = 0;

  function automatic bit ok(int n, int m);
    return (n != 0) && (2 * n <= m);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; e_bclk = 0; e_per = 0; e_min = 65535; e_max = 0; m_k = 0;
    end else begin
      e_bclk = m_run && en && (m_k < m_L / 2);
      e_per  = m_run && en && (m_k == 0);
      if (!m_run) begin
        if (en && ok(int'(n_in), int'(m_in))) begin
          m_run = 1; m_n = int'(n_in); m_m = int'(m_in); m_rem = 0;
          m_L = (m_m + m_n - 1) / m_n; m_k = 0; e_min = 65535; e_max = 0;
        end
      end else if (!en) begin
        m_run = 0;
      end else if (m_k == m_L - 1) begin
        if (m_L < e_min) e_min = m_L;
        if (m_L > e_max) e_max = m_L;
        m_rem = m_rem + m_L * m_n - m_m;
        if (ok(int'(n_in), int'(m_in))) begin
          if (int'(n_in) != m_n || int'(m_in) != m_m) m_rem = 0;
          m_n = int'(n_in); m_m = int'(m_in);
          m_L = (m_m - m_rem + m_n - 1) / m_n; m_k = 0;
        end else m_run = 0;
      end else m_k++;
    end
  end

  task automatic check(string what, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    check("bclk_o vs model", int'(bclk_o), int'(e_bclk));
    check("period_o vs model", int'(period_o), int'(e_per));
    check("min_len_o vs model", int'(min_len_o), e_min);
    check("max_len_o vs model", int'(max_len_o), e_max);
  end

  task automatic wait_pulse();
    for (int i = 0; i < 20000 && !period_o; i++) @(negedge clk);
  endtask

  task automatic count_pulses(int cyc, output int c);
    c = 0;
    for (int i = 0; i < cyc; i++) begin
      if (period_o) c++;
      @(negedge clk);
    end
  endtask

  task automatic measure(output int len, output int hic);
    len = 0; hic = 0;
    wait_pulse();
    for (int i = 0; i < 20000; i++) begin
      len++;
      if (bclk_o) hic++;
      @(negedge clk);
      if (period_o) break;
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int c, len, hic;
    repeat (3) @(negedge clk);
    rst_n = 1; cmp_on = 1;
    @(negedge clk);
    req = "R9";
    check("bclk_o after reset", int'(bclk_o), 0);
    check("period_o after reset", int'(period_o), 0);
    req = "R7";
    check("min_len_o reset", int'(min_len_o), 65535);
    check("max_len_o reset", int'(max_len_o), 0);

    req = "R8"; n_in = 192; m_in = 625; en = 1;
    @(negedge clk);
    check("no strobe one edge after enable", int'(period_o), 0);
    @(negedge clk);
    check("first strobe two edges after enable", int'(period_o), 1);

    req = "R1"; wait_pulse();
    count_pulses(625, c);
    check("strobes in 625 cycles at 192/625", c, 192);
    req = "R2";
    check("min period 192/625", int'(min_len_o), 3);
    check("max period 192/625", int'(max_len_o), 4);

    req = "R6";
    wait_pulse(); @(negedge clk);
    n_in = 2; m_in = 7;
    check("old period keeps running", int'(period_o), 0);
    measure(len, hic);
    req = "R3";
    check("first period length after 2/7 load", len, 4);
    check("first period high count after 2/7 load", hic, 2);
    repeat (40) @(negedge clk);

    req = "R8"; en = 0;
    @(negedge clk);
    check("bclk low after disable", int'(bclk_o), 0);
    count_pulses(20, c);
    check("no strobes while disabled", c, 0);

    req = "R7"; n_in = 441; m_in = 6250; en = 1;
    repeat (2) @(negedge clk);
    check("min cleared on restart", int'(min_len_o), 65535);
    check("max cleared on restart", int'(max_len_o), 0);
    req = "R1"; wait_pulse();
    count_pulses(6250, c);
    check("strobes in 6250 cycles at 441/6250", c, 441);
    req = "R2";
    check("min period 441/6250", int'(min_len_o), 14);
    check("max period 441/6250", int'(max_len_o), 15);

    req = "R5"; n_in = 0;
    repeat (40) @(negedge clk);
    count_pulses(40, c);
    check("stop at boundary on N=0", c, 0);
    check("bclk low after invalid stop", int'(bclk_o), 0);
    en = 0; @(negedge clk);
    n_in = 400; m_in = 625; en = 1;
    count_pulses(50, c);
    check("idle stays idle with 2N>M", c, 0);
    check("bclk low with 2N>M", int'(bclk_o), 0);

    req = "R3"; en = 0; @(negedge clk);
    n_in = 3; m_in = 6; en = 1;
    measure(len, hic);
    check("period length at N=3 M=6", len, 2);
    check("high count at N=3 M=6", hic, 1);
    measure(len, hic);
    check("second period length at N=3 M=6", len, 2);
    req = "R4";
    check("strobe coincides with high", int'(period_o & bclk_o), 1);

    en = 0;
    repeat (5) @(negedge clk);
    cmp_on = 0;
    summary();
    $finish;
  end
endmodule